// File: doc/BRIEF.md
# Power-up Sequencer with Soft-Start Ramp and Setpoint Clamp

This block brings a peak-current LED controller out of undervoltage lockout in a fixed order. Two comparator flags from the supply monitor report the supply level: one says it is above the turn-on threshold and the other says it is below the turn-off threshold. The block turns these into a supply-good state with hysteresis. When supply-good is newly reached, the block starts a fresh sequence. It first holds the gate drive off and the soft-start level at zero for a programmable number of clocks. It then enables the drive and raises a digital soft-start level by a fixed step every clock until the level reaches full scale.

The peak-current setpoint handed to the current comparator is the smaller of two values, the soft-start level and an externally forced dimming code, divided by a fixed ratio. A dimming code below full scale therefore lowers the peak current. An over-temperature flag, whose hysteresis is built outside the block, gates the drive off while it is high. A protection latch, set by the fault counter elsewhere in the controller, also keeps the drive off. The latch is released only by a new power-up, which requires the supply to drop below the off threshold and then rise above the on threshold.

Top module: `softstart_seq`

## Requirements
- R1: After reset the phase output is off (code 0), the drive enable is low, the soft-start level is zero and the fault latch is clear.
- R2: Supply-good is set by the above-on flag and cleared only by the below-off flag; the off flag wins when both are high, and with neither flag high the state is kept.
- R3: The phase code is 0 off, 1 delay, 2 ramp, 3 run. A new supply-good moves off to delay one clock later, and the delay phase lasts exactly DELAY_CYC clocks, with the drive low and the level at zero throughout.
- R4: In the ramp phase the level rises by RAMP_STEP each clock, starting from zero, and saturates at LVL_MAX = SP_MAX * RATIO.
- R5: The phase moves from ramp to run on the clock after the level reaches LVL_MAX. The drive is enabled in ramp and run unless it is gated.
- R6: The setpoint output equals floor(min(level, dim_code) / RATIO), and never exceeds SP_MAX.
- R7: A high over-temperature flag forces the drive low in the same cycle and changes neither the phase nor the level. The drive returns when the flag clears.
- R8: A fault pulse sets the latch one clock later, and the set latch holds the drive low. The latch is not cleared by the on flag while supply-good is already held. It is cleared when a new sequence starts.
- R9: Loss of supply-good returns the phase to off one clock later and clears the level on the following clock. The next power-up ramps again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_above_on | input | 1 | Supply above turn-on threshold |
| vcc_below_off | input | 1 | Supply below turn-off threshold |
| therm_hot | input | 1 | Over-temperature flag (hysteresis applied externally) |
| fault_set | input | 1 | Request to set the protection latch |
| dim_code | input | LVL_W | Forced analog-dimming level, same scale as the soft-start level |
| drv_enable | output | 1 | Gate drive permitted |
| ss_level | output | LVL_W | Current soft-start level |
| ipk_set | output | SP_W | Peak-current setpoint |
| fault_latched | output | 1 | Protection latch state |
| phase | output | 2 | Sequencer phase code |

## Verification
Each power-up is followed cycle by cycle through every delay and ramp clock. The level expected at ramp clock k is min(k*RAMP_STEP, LVL_MAX), so the step size, the saturation point and the exact entry into run are each confirmed. While the sequencer is in run, the setpoint is swept over every dimming code. This separates the part of the range where the clamp applies from the part where the ramp value wins, and it shows whether the division is floored. Separate scenarios cover over-temperature gating, a repeated on flag without a preceding off flag, both supply flags high together, and supply loss in mid-ramp. Together these show which events restart the sequence and clear the latch.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_DELAY = 2'd1,
    PH_RAMP  = 2'd2,
    PH_RUN   = 2'd3
  } ss_phase_e;
endpackage

// File: rtl/ss_supply_hyst.sv
module ss_supply_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic above_on,
  input  logic below_off,
  output logic supply_ok
);
  logic ok_q, ok_d;

  always_comb begin
    ok_d = ok_q;
    if (below_off)     ok_d = 1'b0;
    else if (above_on) ok_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= ok_d;
  end

  assign supply_ok = ok_q;

  // R2
  off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    below_off |=> !supply_ok);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!below_off && !above_on) |=> supply_ok == $past(supply_ok));
endmodule

// File: rtl/ss_phase_ctl.sv
module ss_phase_ctl
  import ss_pkg::*;
#(
  parameter int DELAY_CYC = 20
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      supply_ok,
  input  logic      level_full,
  output ss_phase_e phase,
  output logic      restart
);
  localparam int DLY_W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DELAY_CYC - 1);

  ss_phase_e        ph_q, ph_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign restart = supply_ok && (ph_q == PH_OFF);
  assign cnt_en  = (ph_q == PH_DELAY);

  always_comb begin
    ph_d = ph_q;
    if (!supply_ok) begin
      ph_d = PH_OFF;
    end else begin
      unique case (ph_q)
        PH_OFF:   ph_d = PH_DELAY;
        PH_DELAY: if (cnt_q == DLY_LAST) ph_d = PH_RAMP;
        PH_RAMP:  if (level_full) ph_d = PH_RUN;
        PH_RUN:   ph_d = PH_RUN;
        default:  ph_d = PH_OFF;
      endcase
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_OFF;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase = ph_q;

  // R3
  delay_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DELAY) |-> (cnt_q <= DLY_LAST));
  // R3
  off_to_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_OFF && supply_ok) |=> (ph_q == PH_DELAY));
  // R9
  loss_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (ph_q == PH_OFF));
endmodule

// File: rtl/ss_ramp_gen.sv
module ss_ramp_gen
  import ss_pkg::*;
#(
  parameter int LVL_W     = 10,
  parameter int LVL_MAX   = 765,
  parameter int RAMP_STEP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ss_phase_e        phase,
  output logic [LVL_W-1:0] level,
  output logic             level_full
);
  localparam logic [LVL_W:0]   STEP_X = (LVL_W+1)'(RAMP_STEP);
  localparam logic [LVL_W:0]   MAX_X  = (LVL_W+1)'(LVL_MAX);
  localparam logic [LVL_W-1:0] MAX_L  = LVL_W'(LVL_MAX);

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [LVL_W:0]   sum;
  logic             hold_zero, step_en;

  assign hold_zero = (phase == PH_OFF) || (phase == PH_DELAY);
  assign step_en   = (phase == PH_RAMP);
  assign sum       = {1'b0, lvl_q} + STEP_X;

  always_comb begin
    lvl_d = lvl_q;
    if (hold_zero) begin
      lvl_d = '0;
    end else if (step_en) begin
      if (sum >= MAX_X) lvl_d = MAX_L;
      else              lvl_d = sum[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign level      = lvl_q;
  assign level_full = (lvl_q == MAX_L);

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= MAX_L);
  // R4
  ramp_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RAMP) |=> (lvl_q >= $past(lvl_q)));
  // R3
  delay_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DELAY && $past(phase) == PH_DELAY) |-> (lvl_q == '0));
endmodule

// File: rtl/ss_setpoint.sv
module ss_setpoint #(
  parameter int LVL_W  = 10,
  parameter int SP_W   = 8,
  parameter int RATIO  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] dim_code,
  output logic [SP_W-1:0]  ipk
);
  localparam int          SP_MAX  = (1 << SP_W) - 1;
  localparam logic [LVL_W-1:0] SP_MAX_L = LVL_W'(SP_MAX);

  logic [LVL_W-1:0] sel;
  logic [LVL_W-1:0] quot;

  assign sel = (level < dim_code) ? level : dim_code;

  generate
    if (RATIO == 1) begin : g_unity
      assign quot = sel;
    end else begin : g_div
      localparam logic [LVL_W-1:0] RATIO_L = LVL_W'(RATIO);
      assign quot = sel / RATIO_L;
    end
  endgenerate

  always_comb begin
    if (quot > SP_MAX_L) ipk = SP_W'(SP_MAX);
    else                 ipk = quot[SP_W-1:0];
  end

  // R6
  clamp_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(ipk) * RATIO) <= 32'(dim_code));
  // R6
  clamp_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(ipk) * RATIO) <= 32'(level));
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_pkg::*;
#(
  parameter int SP_W      = 8,
  parameter int RATIO     = 3,
  parameter int DELAY_CYC = 20,
  parameter int RAMP_STEP = 16,
  localparam int SP_MAX   = (1 << SP_W) - 1,
  localparam int LVL_MAX  = SP_MAX * RATIO,
  localparam int LVL_W    = $clog2(LVL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vcc_above_on,
  input  logic             vcc_below_off,
  input  logic             therm_hot,
  input  logic             fault_set,
  input  logic [LVL_W-1:0] dim_code,
  output logic             drv_enable,
  output logic [LVL_W-1:0] ss_level,
  output logic [SP_W-1:0]  ipk_set,
  output logic             fault_latched,
  output logic [1:0]       phase
);
  logic       rst_s1, rst_s2;
  logic       supply_ok, restart, level_full;
  logic       latch_q, latch_d;
  ss_phase_e  ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  ss_supply_hyst u_hyst (
    .clk       (clk),
    .rst_n     (rst_s2),
    .above_on  (vcc_above_on),
    .below_off (vcc_below_off),
    .supply_ok (supply_ok)
  );

  ss_phase_ctl #(.DELAY_CYC(DELAY_CYC)) u_phase (
    .clk        (clk),
    .rst_n      (rst_s2),
    .supply_ok  (supply_ok),
    .level_full (level_full),
    .phase      (ph),
    .restart    (restart)
  );

  ss_ramp_gen #(.LVL_W(LVL_W), .LVL_MAX(LVL_MAX), .RAMP_STEP(RAMP_STEP)) u_ramp (
    .clk        (clk),
    .rst_n      (rst_s2),
    .phase      (ph),
    .level      (ss_level),
    .level_full (level_full)
  );

  ss_setpoint #(.LVL_W(LVL_W), .SP_W(SP_W), .RATIO(RATIO)) u_sp (
    .clk      (clk),
    .rst_n    (rst_s2),
    .level    (ss_level),
    .dim_code (dim_code),
    .ipk      (ipk_set)
  );

  always_comb begin
    latch_d = latch_q;
    if (restart)        latch_d = 1'b0;
    else if (fault_set) latch_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) latch_q <= 1'b0;
    else         latch_q <= latch_d;
  end

  assign fault_latched = latch_q;
  assign phase         = ph;
  assign drv_enable    = ((ph == PH_RAMP) || (ph == PH_RUN)) && !therm_hot && !latch_q;

  // R3
  drive_off_early_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    (ph == PH_OFF || ph == PH_DELAY) |-> !drv_enable);
  // R8
  latch_cleared_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    (ph == PH_DELAY && $past(ph) == PH_OFF) |-> !fault_latched);
  // R7
  therm_gate_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    therm_hot |-> !drv_enable);
endmodule

// File: tb/softstart_seq_tb_top.sv
module softstart_seq_tb_top;
  localparam int SP_W      = 8;
  localparam int RATIO     = 3;
  localparam int DELAY_CYC = 20;
  localparam int RAMP_STEP = 16;
  localparam int SP_MAX    = (1 << SP_W) - 1;
  localparam int LVL_MAX   = SP_MAX * RATIO;
  localparam int LVL_W     = $clog2(LVL_MAX + 1);
  localparam int K_FULL    = (LVL_MAX + RAMP_STEP - 1) / RAMP_STEP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_above_on = 1'b0, vcc_below_off = 1'b0, therm_hot = 1'b0, fault_set = 1'b0;
  logic [LVL_W-1:0] dim_code = '1;
  logic drv_enable, fault_latched;
  logic [LVL_W-1:0] ss_level;
  logic [SP_W-1:0] ipk_set;
  logic [1:0] phase;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  softstart_seq #(.SP_W(SP_W), .RATIO(RATIO), .DELAY_CYC(DELAY_CYC), .RAMP_STEP(RAMP_STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .vcc_above_on(vcc_above_on), .vcc_below_off(vcc_below_off),
    .therm_hot(therm_hot), .fault_set(fault_set), .dim_code(dim_code),
    .drv_enable(drv_enable), .ss_level(ss_level), .ipk_set(ipk_set),
    .fault_latched(fault_latched), .phase(phase)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Power-up from off: checks R3 delay, R4 ramp, R5 run entry, R6 setpoint during ramp.
  task automatic power_up(input bool_latched_expected);
    vcc_above_on = 1'b1;
    step();
    vcc_above_on = 1'b0;
    chk("R2", "phase one clock after on flag", int'(phase), 0);
    for (int j = 0; j < DELAY_CYC; j++) begin
      step();
      chk("R3", "delay phase", int'(phase), 1);
      chk("R3", "delay level", int'(ss_level), 0);
      chk("R3", "delay drive", int'(drv_enable), 0);
      if (j == 0) chk("R8", "latch after restart", int'(fault_latched), 0);
    end
    for (int k = 0; k <= K_FULL + 3; k++) begin
      int exp_lvl;
      step();
      exp_lvl = (k * RAMP_STEP > LVL_MAX) ? LVL_MAX : k * RAMP_STEP;
      chk("R4", "ramp level", int'(ss_level), exp_lvl);
      chk("R5", "ramp/run phase", int'(phase), (k > K_FULL) ? 3 : 2);
      chk("R5", "drive in ramp/run", int'(drv_enable), 1);
      chk("R6", "setpoint during ramp", int'(ipk_set), exp_lvl / RATIO);
    end
  endtask

  // Accepts a dummy argument type for compactness
  typedef int bool_latched_expected_t;

  initial begin
    repeat (3) step();
    chk("R1", "reset phase", int'(phase), 0);
    chk("R1", "reset drive", int'(drv_enable), 0);
    chk("R1", "reset level", int'(ss_level), 0);
    chk("R1", "reset latch", int'(fault_latched), 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R2", "no supply stays off", int'(phase), 0);

    power_up(0);

    // R2: neither flag keeps supply-good
    repeat (5) step();
    chk("R2", "hold with no flags", int'(phase), 3);

    // R6: sweep all dimming codes in run
    for (int d = 0; d < (1 << LVL_W); d++) begin
      int sel;
      dim_code = LVL_W'(d);
      #1;
      sel = (d < LVL_MAX) ? d : LVL_MAX;
      chk("R6", "setpoint sweep", int'(ipk_set), sel / RATIO);
    end
    dim_code = '1;

    // R7: thermal gating
    step();
    therm_hot = 1'b1;
    #1;
    chk("R7", "drive gated same cycle", int'(drv_enable), 0);
    repeat (3) step();
    chk("R7", "phase unchanged while hot", int'(phase), 3);
    chk("R7", "level unchanged while hot", int'(ss_level), LVL_MAX);
    therm_hot = 1'b0;
    #1;
    chk("R7", "drive back after cool", int'(drv_enable), 1);

    // R8: fault latch
    fault_set = 1'b1;
    step();
    fault_set = 1'b0;
    chk("R8", "latch set", int'(fault_latched), 1);
    chk("R8", "drive off when latched", int'(drv_enable), 0);
    vcc_above_on = 1'b1;
    repeat (3) step();
    vcc_above_on = 1'b0;
    step();
    chk("R8", "on flag alone keeps latch", int'(fault_latched), 1);
    chk("R8", "phase kept without off", int'(phase), 3);

    // R9: supply loss
    vcc_below_off = 1'b1;
    step();
    vcc_below_off = 1'b0;
    chk("R9", "phase before off registered", int'(phase), 3);
    step();
    chk("R9", "phase off after loss", int'(phase), 0);
    chk("R9", "level one clock before clear", int'(ss_level), LVL_MAX);
    step();
    chk("R9", "level cleared", int'(ss_level), 0);
    repeat (4) step();
    chk("R2", "stays off without on flag", int'(phase), 0);
    chk("R8", "latch held while off", int'(fault_latched), 1);

    power_up(0);
    chk("R8", "latch cleared by supply cycle", int'(fault_latched), 0);

    // R2: both flags high, off wins
    vcc_above_on = 1'b1;
    vcc_below_off = 1'b1;
    step();
    vcc_above_on = 1'b0;
    vcc_below_off = 1'b0;
    step();
    chk("R2", "off flag wins", int'(phase), 0);
    step();

    // R9: loss in mid-ramp then ramp restarts from zero
    vcc_above_on = 1'b1;
    step();
    vcc_above_on = 1'b0;
    repeat (DELAY_CYC + 10) step();
    chk("R4", "mid-ramp level", int'(ss_level), 9 * RAMP_STEP);
    vcc_below_off = 1'b1;
    step();
    vcc_below_off = 1'b0;
    step();
    chk("R9", "off after mid-ramp loss", int'(phase), 0);
    step();
    chk("R9", "level zero after mid-ramp loss", int'(ss_level), 0);
    power_up(0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule